// File: doc/BRIEF.md
# Exception Control Coprocessor Unit

This block holds the exception and interrupt control state of a simple in-order RISC core. It keeps four registers: status, cause, exception restart address and faulting address. When the pipeline reports a fault or trap, or when an enabled interrupt is pending, the unit takes the exception in that cycle. It records where execution must resume and pushes a three-level stack of privilege-mode and interrupt-enable pairs. It then writes the exception code and raises a redirect to the fixed general exception vector.

A return command pops the mode stack, so the previous mode and enable come back. Kernel software reads and writes the registers through a move-to/move-from port. An access made from user mode does not reach the registers and raises a coprocessor-unusable exception instead. Pending interrupts come from six external lines, which are sampled once per clock, and from two software-set bits. Each pending bit is gated by its own mask bit and by the current enable.

Top module: `excp_ctrl_top`

## Requirements
- R1: After reset the status, cause, restart-address and fault-address registers all read 0. This means kernel mode with interrupts disabled, and redirect_o is low while nothing is requested.
- R2: Taking an exception moves the current pair to previous and the previous pair to old, and clears the current pair (kernel, enable 0). The status stack bits are bit0 current enable, bit1 current mode (1 = user), bit2/bit3 previous enable/mode and bit4/bit5 old enable/mode. The interrupt mask occupies bits 15:8.
- R3: On an exception the restart-address register (selector 14) is loaded with pc_i. When bd_i is high it is loaded with pc_i minus 4 instead, and cause bit 31 holds bd_i.
- R4: On an exception, cause bits 6:2 are loaded with the code of the exception taken. Interrupts use code 0, address faults 4 and 5, and system calls 8.
- R5: redirect_o is high in the cycle an exception is taken, and redirect_pc_o then equals 0x80000080. A requested exception overrides a return command or a register write issued in the same cycle.
- R6: A return command with no exception in that cycle copies old to previous and previous to current, and leaves old unchanged.
- R7: Cause bits 15:10 show irq_i as sampled one clock earlier. Cause bits 9:8 are the software pending bits. A move-to on cause writes only those two bits.
- R8: An interrupt (code 0) is taken when the current enable is 1 and some pending bit has its mask bit set in status 15:8. A pending bit with its mask clear causes nothing.
- R9: A move-to or move-from issued in user mode raises exception code 11. It changes no register, and rdata_o stays 0.
- R10: The fault-address register (selector 8) captures badva_i only for codes 4 and 5, and keeps its value for all other exceptions.
- R11: Priority among simultaneous sources is: a requested exception, then a user-mode register access, then an interrupt.
- R12: A kernel move-from returns the selected register on rdata_o in the same cycle, using selectors 12 for status, 13 for cause, 14 for restart address and 8 for fault address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | One-cycle exception strobe from the pipeline |
| exc_code_i | input | 5 | Code of the requested exception |
| pc_i | input | 32 | PC of the instruction at the exception point |
| bd_i | input | 1 | That instruction sits in a branch delay slot |
| badva_i | input | 32 | Faulting data address for address faults |
| rfe_i | input | 1 | Return-from-exception command |
| irq_i | input | 6 | External interrupt lines |
| mt_i | input | 1 | Move-to register strobe |
| mf_i | input | 1 | Move-from register strobe |
| reg_sel_i | input | 5 | Register selector |
| wdata_i | input | 32 | Move-to data |
| rdata_o | output | 32 | Move-from data |
| redirect_o | output | 1 | Exception taken this cycle |
| redirect_pc_o | output | 32 | Next PC when redirecting |

## Verification
Three kinds of event can fall in the same cycle. A requested exception can coincide with a return command or with a kernel write to the restart address. The bench issues each pair in a single cycle and then reads status and the restart address: it expects a push, not a pop, and the faulting PC, not the written value. In a further case a software interrupt becomes enabled just as an address fault is requested, and the cause code must read 4, not 0.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_ADL  = 5'd4;
  localparam logic [4:0] CODE_ADS  = 5'd5;
  localparam logic [4:0] CODE_SYS  = 5'd8;
  localparam logic [4:0] CODE_CPU  = 5'd11;

  localparam logic [4:0] SEL_BADVA = 5'd8;
  localparam logic [4:0] SEL_STAT  = 5'd12;
  localparam logic [4:0] SEL_CAUSE = 5'd13;
  localparam logic [4:0] SEL_EPC   = 5'd14;

  localparam int unsigned IP_LSB   = 8;
  localparam int unsigned CODE_LSB = 2;

  typedef struct packed {
    logic ku;
    logic ie;
  } mode_pair_t;
endpackage

// File: rtl/excp_mode_stack.sv
module excp_mode_stack
  import excp_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned NIRQ  = 8,
  localparam int unsigned SW   = 2 * DEPTH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wr_i,
  input  logic [SW-1:0]   stk_wdata_i,
  input  logic [NIRQ-1:0] im_wdata_i,
  output logic [SW-1:0]   stk_o,
  output logic [NIRQ-1:0] im_o
);
  mode_pair_t stk_q [DEPTH];
  logic [NIRQ-1:0] im_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    mode_pair_t nxt;
    always_comb begin
      nxt = stk_q[i];
      if (push_i) begin
        if (i == 0) nxt = '0;
        else        nxt = stk_q[(i == 0) ? 0 : i - 1];
      end else if (pop_i) begin
        if (i < DEPTH - 1) nxt = stk_q[(i < DEPTH - 1) ? i + 1 : i];
      end else if (wr_i) begin
        nxt = stk_wdata_i[2*i +: 2];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stk_q[i] <= '0;
      else         stk_q[i] <= nxt;
    end

    assign stk_o[2*i +: 2] = stk_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 im_q <= '0;
    else if (wr_i && !push_i && !pop_i) im_q <= im_wdata_i;
  end

  assign im_o = im_q;
endmodule

// File: rtl/excp_irq_gate.sv
module excp_irq_gate #(
  parameter int unsigned NHW  = 6,
  parameter int unsigned NSW  = 2,
  localparam int unsigned NIRQ = NHW + NSW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NHW-1:0]  irq_i,
  input  logic            sw_wr_i,
  input  logic [NSW-1:0]  sw_wdata_i,
  input  logic [NIRQ-1:0] im_i,
  input  logic            ie_i,
  output logic [NIRQ-1:0] ip_o,
  output logic            pend_o
);
  logic [NHW-1:0] hw_q;
  logic [NSW-1:0] sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q <= '0;
      sw_q <= '0;
    end else begin
      hw_q <= irq_i;
      if (sw_wr_i) sw_q <= sw_wdata_i;
    end
  end

  assign ip_o   = {hw_q, sw_q};
  assign pend_o = ie_i & (|(ip_o & im_i));
endmodule

// File: rtl/excp_arbiter.sv
module excp_arbiter
  import excp_pkg::*;
(
  input  logic       req_i,
  input  logic [4:0] req_code_i,
  input  logic       cpu_viol_i,
  input  logic       irq_pend_i,
  output logic       take_o,
  output logic [4:0] code_o
);
  always_comb begin
    take_o = 1'b1;
    if (req_i)           code_o = req_code_i;
    else if (cpu_viol_i) code_o = CODE_CPU;
    else begin
      code_o = CODE_INT;
      take_o = irq_pend_i;
    end
  end
endmodule

// File: rtl/excp_ctrl_top.sv
module excp_ctrl_top
  import excp_pkg::*;
#(
  parameter int unsigned  DW     = 32,
  parameter int unsigned  DEPTH  = 3,
  parameter int unsigned  NHW    = 6,
  parameter int unsigned  NSW    = 2,
  parameter logic [31:0]  VECTOR = 32'h8000_0080,
  localparam int unsigned NIRQ   = NHW + NSW,
  localparam int unsigned SW     = 2 * DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_req_i,
  input  logic [4:0]    exc_code_i,
  input  logic [DW-1:0] pc_i,
  input  logic          bd_i,
  input  logic [DW-1:0] badva_i,
  input  logic          rfe_i,
  input  logic [NHW-1:0] irq_i,
  input  logic          mt_i,
  input  logic          mf_i,
  input  logic [4:0]    reg_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          redirect_o,
  output logic [DW-1:0] redirect_pc_o
);
  logic [SW-1:0]   stk;
  logic [NIRQ-1:0] im, ip;
  logic            kernel, user_acc, irq_pend, take;
  logic [4:0]      take_code;
  logic            mt_ok, rfe_ok;
  logic [4:0]      code_q;
  logic            bd_q;
  logic [DW-1:0]   epc_q, badva_q;
  logic [DW-1:0]   status_w, cause_w;

  assign kernel   = ~stk[1];
  assign user_acc = (mt_i | mf_i) & ~kernel;
  assign mt_ok    = mt_i & kernel & ~take;
  assign rfe_ok   = rfe_i & ~take;

  excp_arbiter u_arb (
    .req_i      (exc_req_i),
    .req_code_i (exc_code_i),
    .cpu_viol_i (user_acc),
    .irq_pend_i (irq_pend),
    .take_o     (take),
    .code_o     (take_code)
  );

  excp_mode_stack #(.DEPTH(DEPTH), .NIRQ(NIRQ)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (take),
    .pop_i       (rfe_ok),
    .wr_i        (mt_ok && reg_sel_i == SEL_STAT),
    .stk_wdata_i (wdata_i[SW-1:0]),
    .im_wdata_i  (wdata_i[IP_LSB +: NIRQ]),
    .stk_o       (stk),
    .im_o        (im)
  );

  excp_irq_gate #(.NHW(NHW), .NSW(NSW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .sw_wr_i    (mt_ok && reg_sel_i == SEL_CAUSE),
    .sw_wdata_i (wdata_i[IP_LSB +: NSW]),
    .im_i       (im),
    .ie_i       (stk[0]),
    .ip_o       (ip),
    .pend_o     (irq_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      bd_q    <= 1'b0;
      epc_q   <= '0;
      badva_q <= '0;
    end else if (take) begin
      code_q <= take_code;
      bd_q   <= bd_i;
      epc_q  <= bd_i ? pc_i - DW'(4) : pc_i;
      if (take_code == CODE_ADL || take_code == CODE_ADS) badva_q <= badva_i;
    end else if (mt_ok && reg_sel_i == SEL_EPC) begin
      epc_q <= wdata_i;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[SW-1:0] = stk;
    status_w[IP_LSB +: NIRQ] = im;
    cause_w = '0;
    cause_w[DW-1] = bd_q;
    cause_w[IP_LSB +: NIRQ] = ip;
    cause_w[CODE_LSB +: 5] = code_q;
  end

  always_comb begin
    rdata_o = '0;
    if (mf_i && kernel) begin
      case (reg_sel_i)
        SEL_STAT:  rdata_o = status_w;
        SEL_CAUSE: rdata_o = cause_w;
        SEL_EPC:   rdata_o = epc_q;
        SEL_BADVA: rdata_o = badva_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign redirect_o    = take;
  assign redirect_pc_o = take ? DW'(VECTOR) : '0;
endmodule

// File: rtl/excp_ctrl_chk.sv
module excp_ctrl_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NIRQ = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            redirect_o,
  input logic [DW-1:0]   redirect_pc_o,
  input logic            rfe_i,
  input logic            mt_i,
  input logic            mf_i,
  input logic            bd_i,
  input logic [DW-1:0]   pc_i,
  input logic [5:0]      stk,
  input logic [NIRQ-1:0] ip,
  input logic [NIRQ-1:0] im,
  input logic [DW-1:0]   epc_q,
  input logic [DW-1:0]   rdata_o
);
  assert_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> stk[1:0] == 2'b00 && stk[3:2] == $past(stk[1:0]) && stk[5:4] == $past(stk[3:2]));

  assert_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_i && !redirect_o |=> stk[1:0] == $past(stk[3:2]) && stk[3:2] == $past(stk[5:4]) && stk[5:4] == $past(stk[5:4]));

  assert_bd_epc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && bd_i |=> epc_q == $past(pc_i) - DW'(4));

  assert_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> redirect_pc_o == DW'(32'h8000_0080));

  assert_user_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mt_i || mf_i) && stk[1] |-> redirect_o && rdata_o == '0);

  assert_irq_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk[0] && (|(ip & im)) |-> redirect_o);
endmodule

bind excp_ctrl_top excp_ctrl_chk #(.DW(DW), .NIRQ(NIRQ)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .rfe_i         (rfe_i),
  .mt_i          (mt_i),
  .mf_i          (mf_i),
  .bd_i          (bd_i),
  .pc_i          (pc_i),
  .stk           (stk),
  .ip            (ip),
  .im            (im),
  .epc_q         (epc_q),
  .rdata_o       (rdata_o)
);

// File: tb/tb_excp_ctrl_top.sv
`timescale 1ns/1ps
module tb_excp_ctrl_top;
  localparam logic [31:0] VEC = 32'h8000_0080;
  localparam logic [4:0] S_BADVA = 5'd8, S_STAT = 5'd12, S_CAUSE = 5'd13, S_EPC = 5'd14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic exc_req_i, bd_i, rfe_i, mt_i, mf_i;
  logic [4:0] exc_code_i, reg_sel_i;
  logic [31:0] pc_i = '0, badva_i, wdata_i;
  logic [5:0] irq_i = '0;
  logic [31:0] rdata_o, redirect_pc_o;
  logic redirect_o;

  int ntests = 0, nfail = 0;
  logic chk_rd = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  excp_ctrl_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .exc_req_i(exc_req_i), .exc_code_i(exc_code_i),
    .pc_i(pc_i), .bd_i(bd_i), .badva_i(badva_i), .rfe_i(rfe_i), .irq_i(irq_i),
    .mt_i(mt_i), .mf_i(mf_i), .reg_sel_i(reg_sel_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for move-from reads
  always @(negedge clk) begin
    if (chk_rd && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, rdata_o, e);
    end
  end

  task automatic clr();
    exc_req_i = 0; exc_code_i = '0; bd_i = 0; badva_i = '0; rfe_i = 0;
    mt_i = 0; mf_i = 0; reg_sel_i = '0; wdata_i = '0; chk_rd = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1; clr();
  endtask

  task automatic rd(logic [4:0] sel, logic [31:0] exp, string tag);
    cyc();
    mf_i = 1; reg_sel_i = sel; chk_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic wr(logic [4:0] sel, logic [31:0] val);
    cyc();
    mt_i = 1; reg_sel_i = sel; wdata_i = val;
  endtask

  task automatic redir(logic exp, string tag);
    @(negedge clk);
    chk(tag, {31'b0, redirect_o}, {31'b0, exp});
    if (exp) chk({tag, " vector"}, redirect_pc_o, VEC);
  endtask

  task automatic exc(logic [4:0] code, logic [31:0] pc, logic bd, logic [31:0] va);
    cyc();
    exc_req_i = 1; exc_code_i = code; pc_i = pc; bd_i = bd; badva_i = va;
  endtask

  initial begin
    #(20 * 20000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    // R1 reset state
    redir(1'b0, "R1 no redirect after reset");
    rd(S_STAT, 32'h0, "R1 status reset");
    rd(S_CAUSE, 32'h0, "R1 cause reset");
    rd(S_EPC, 32'h0, "R1 epc reset");
    rd(S_BADVA, 32'h0, "R1 badva reset");

    // R12 write/read status, R6 pop into user mode
    wr(S_STAT, 32'h0000_000C);
    rd(S_STAT, 32'h0000_000C, "R12 status readback");
    cyc(); rfe_i = 1;
    // now user: R9 move-from traps
    cyc(); mf_i = 1; reg_sel_i = S_STAT; pc_i = 32'h100;
    @(negedge clk);
    chk("R9 user mf redirect", {31'b0, redirect_o}, 32'h1);
    chk("R9 user mf rdata zero", rdata_o, 32'h0);
    rd(S_STAT, 32'h0000_000C, "R6 R2 pop then push");
    rd(S_CAUSE, 32'h0000_002C, "R9 code 11");
    rd(S_EPC, 32'h0000_0100, "R3 epc user trap");
    cyc(); rfe_i = 1;
    cyc(); mt_i = 1; reg_sel_i = S_EPC; wdata_i = 32'hDEAD; pc_i = 32'h200;
    redir(1'b1, "R9 user mt redirect");
    rd(S_EPC, 32'h0000_0200, "R9 user mt write ignored");

    // R3 branch delay, R10 badva, R4 code
    exc(5'd4, 32'h1000, 1'b1, 32'h2222_0001);
    redir(1'b1, "R5 address fault redirect");
    rd(S_EPC, 32'h0000_0FFC, "R3 bd epc minus 4");
    rd(S_CAUSE, 32'h8000_0010, "R3 R4 bd flag and code 4");
    rd(S_BADVA, 32'h2222_0001, "R10 badva captured");
    rd(S_STAT, 32'h0000_0030, "R2 push to old");
    exc(5'd8, 32'h0040_0640, 1'b0, 32'h5555);
    redir(1'b1, "R4 syscall redirect");
    rd(S_CAUSE, 32'h0000_0020, "R4 syscall code 8");
    rd(S_BADVA, 32'h2222_0001, "R10 badva kept on syscall");
    rd(S_EPC, 32'h0040_0640, "R3 epc syscall");

    // R5 exception beats rfe and mt in the same cycle
    wr(S_STAT, 32'h0000_003C);
    exc(5'd5, 32'h8000, 1'b0, 32'h7777); rfe_i = 1;
    redir(1'b1, "R5 exc with rfe redirect");
    rd(S_STAT, 32'h0000_0030, "R5 push wins over rfe");
    rd(S_BADVA, 32'h0000_7777, "R10 badva code 5");
    exc(5'd8, 32'h9000, 1'b0, 32'h0); mt_i = 1; reg_sel_i = S_EPC; wdata_i = 32'h1234;
    rd(S_EPC, 32'h0000_9000, "R5 exc wins over mt");

    // R7 R8 external interrupts
    wr(S_STAT, 32'h0000_0401);
    cyc(); irq_i = 6'b000010; pc_i = 32'h1234_5678;
    redir(1'b0, "R8 unmasked line none");
    cyc(); redir(1'b0, "R8 masked line ignored");
    cyc(); irq_i = 6'b000011;
    redir(1'b0, "R7 line not yet sampled");
    cyc(); redir(1'b1, "R8 interrupt taken");
    cyc(); redir(1'b0, "R8 enable cleared after take");
    rd(S_CAUSE, 32'h0000_0C00, "R7 R4 pending bits and code 0");
    rd(S_EPC, 32'h1234_5678, "R3 epc interrupt");
    rd(S_STAT, 32'h0000_0404, "R2 interrupt push keeps mask");
    cyc(); irq_i = '0;
    cyc();

    // R7 software bits, R11 priority over interrupt
    wr(S_CAUSE, 32'hFFFF_FFFF);
    rd(S_CAUSE, 32'h0000_0300, "R7 only soft bits writable");
    wr(S_STAT, 32'h0000_0101);
    exc(5'd4, 32'h2000, 1'b0, 32'h0ABC);
    redir(1'b1, "R11 redirect with both sources");
    rd(S_CAUSE, 32'h0000_0310, "R11 request beats interrupt");
    wr(S_CAUSE, 32'h0);
    rd(S_CAUSE, 32'h0000_0010, "R7 soft bits cleared");
    rd(5'd3, 32'h0, "R12 unused selector");
    cyc();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule